// File: doc/BRIEF.md
# AXI4-Lite to APB Bridge

This block connects an AXI4-Lite slave port to a single APB completer. Each accepted AXI register access is replayed as exactly one APB transfer. A transfer is one SETUP cycle followed by an ACCESS phase, and the ACCESS phase is stretched for as long as the completer holds its ready input low. There is no limit on how long that stretch can be.

Reads and writes arrive on independent AXI channels and may be offered in the same cycle. The bridge serialises them, so only one APB transfer is ever in flight. When both directions are waiting, the bridge alternates between them. The completer's error flag is returned as the AXI response code, and read data is captured from the APB read bus.

The bridge sits between an AXI fabric and a segment of small peripherals. It handles 32-bit addresses and data.

Top module: `axil_apb_bridge`

## Requirements
- R1: After reset, `apb_sel`, `apb_en`, `axi_bvalid` and `axi_rvalid` are low, and `axi_awready`, `axi_wready` and `axi_arready` are high.
- R2: Every APB transfer starts with one cycle in which `apb_sel` is 1 and `apb_en` is 0. In that cycle `apb_addr`, `apb_write` and (for writes) `apb_wdata` are valid. The next cycle has `apb_sel` and `apb_en` both at 1.
- R3: While `apb_sel` and `apb_en` are high and `apb_ready` is low, the transfer stays in ACCESS. During that time `apb_addr`, `apb_write` and `apb_wdata` do not change, for any number of wait cycles.
- R4: A transfer ends in the cycle after an ACCESS cycle with `apb_ready` high, and `apb_sel` is then low for at least one cycle. Only one transfer is active at a time.
- R5: A write transfer starts only after both the address (AW) and data (W) handshakes have taken place. The two may occur in either order or in the same cycle.
- R6: When a read and a write are both waiting, the direction opposite to the last completed transfer goes first. After reset the write goes first.
- R7: The write response `axi_bresp` is 2'b00 when `apb_err` was low in the completing cycle and 2'b10 when it was high. `axi_rresp` is encoded the same way, and `axi_rdata` equals `apb_rdata` from the completing cycle.
- R8: `axi_bvalid` with `axi_bresp`, and `axi_rvalid` with `axi_rresp` and `axi_rdata`, stay unchanged until `axi_bready` or `axi_rready` is seen high.
- R9: While a write is accepted but its B handshake has not yet occurred, `axi_awready` and `axi_wready` are low. While a read is accepted but its R handshake has not yet occurred, `axi_arready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| axi_awaddr | input | 32 | Write address |
| axi_awvalid | input | 1 | Write address valid |
| axi_awready | output | 1 | Write address ready |
| axi_wdata | input | 32 | Write data |
| axi_wvalid | input | 1 | Write data valid |
| axi_wready | output | 1 | Write data ready |
| axi_bresp | output | 2 | Write response |
| axi_bvalid | output | 1 | Write response valid |
| axi_bready | input | 1 | Write response ready |
| axi_araddr | input | 32 | Read address |
| axi_arvalid | input | 1 | Read address valid |
| axi_arready | output | 1 | Read address ready |
| axi_rdata | output | 32 | Read data |
| axi_rresp | output | 2 | Read response |
| axi_rvalid | output | 1 | Read data valid |
| axi_rready | input | 1 | Read data ready |
| apb_sel | output | 1 | Completer select |
| apb_en | output | 1 | ACCESS phase enable |
| apb_addr | output | 32 | Transfer address |
| apb_write | output | 1 | 1 for write, 0 for read |
| apb_wdata | output | 32 | Write data to completer |
| apb_rdata | input | 32 | Read data from completer |
| apb_ready | input | 1 | Completer ready; low inserts wait states |
| apb_err | input | 1 | Completer error flag |

## Verification
A read request and a write request can reach the bridge in the same cycle. The bench provokes this in two ways:
- Directed pairs issue both requests on the same clock, once from a fresh reset and once after a lone write. An observer on the APB side records the direction of each SETUP cycle, and the recorded order must follow the alternation rule.
- In a long random phase, one writer thread and one reader thread run concurrently on disjoint address ranges with random handshake delays and random wait states.

Every response is compared with a value the bench computes from its own shadow memory and its address-based error rule. The APB observer checks that a new SETUP never overlaps a transfer that is still in progress.

// File: rtl/axil_apb_bridge.sv
module axil_apb_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] axi_awaddr,
  input  logic              axi_awvalid,
  output logic              axi_awready,
  input  logic [DATA_W-1:0] axi_wdata,
  input  logic              axi_wvalid,
  output logic              axi_wready,
  output logic [1:0]        axi_bresp,
  output logic              axi_bvalid,
  input  logic              axi_bready,
  input  logic [ADDR_W-1:0] axi_araddr,
  input  logic              axi_arvalid,
  output logic              axi_arready,
  output logic [DATA_W-1:0] axi_rdata,
  output logic [1:0]        axi_rresp,
  output logic              axi_rvalid,
  input  logic              axi_rready,
  output logic              apb_sel,
  output logic              apb_en,
  output logic [ADDR_W-1:0] apb_addr,
  output logic              apb_write,
  output logic [DATA_W-1:0] apb_wdata,
  input  logic [DATA_W-1:0] apb_rdata,
  input  logic              apb_ready,
  input  logic              apb_err
);

  localparam logic [1:0] RESP_OK  = 2'b00;
  localparam logic [1:0] RESP_ERR = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACCESS} state_t;

  state_t            st;
  logic              aw_have, w_have, ar_have;
  logic [ADDR_W-1:0] aw_q, ar_q;
  logic [DATA_W-1:0] w_q;
  logic              cur_wr, last_wr;
  logic              bvalid_q, rvalid_q;
  logic [1:0]        bresp_q, rresp_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic wr_pend, rd_pend, pick_wr, done;

  assign wr_pend = aw_have & w_have & ~bvalid_q;
  assign rd_pend = ar_have & ~rvalid_q;
  assign pick_wr = wr_pend & (~rd_pend | ~last_wr);
  assign done    = (st == ST_ACCESS) & apb_ready;

  assign axi_awready = ~aw_have;
  assign axi_wready  = ~w_have;
  assign axi_arready = ~ar_have;
  assign axi_bvalid  = bvalid_q;
  assign axi_bresp   = bresp_q;
  assign axi_rvalid  = rvalid_q;
  assign axi_rresp   = rresp_q;
  assign axi_rdata   = rdata_q;

  assign apb_sel   = (st != ST_IDLE);
  assign apb_en    = (st == ST_ACCESS);
  assign apb_addr  = addr_q;
  assign apb_write = cur_wr;
  assign apb_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_have <= 1'b0;
      w_have  <= 1'b0;
      aw_q    <= '0;
      w_q     <= '0;
    end else begin
      if (axi_awvalid && !aw_have) begin
        aw_have <= 1'b1;
        aw_q    <= axi_awaddr;
      end
      if (axi_wvalid && !w_have) begin
        w_have <= 1'b1;
        w_q    <= axi_wdata;
      end
      if (bvalid_q && axi_bready) begin
        aw_have <= 1'b0;
        w_have  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_have <= 1'b0;
      ar_q    <= '0;
    end else begin
      if (axi_arvalid && !ar_have) begin
        ar_have <= 1'b1;
        ar_q    <= axi_araddr;
      end
      if (rvalid_q && axi_rready) ar_have <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_wr  <= 1'b0;
      last_wr <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (wr_pend || rd_pend) begin
          st      <= ST_SETUP;
          cur_wr  <= pick_wr;
          addr_q  <= pick_wr ? aw_q : ar_q;
          wdata_q <= w_q;
        end
        ST_SETUP:  st <= ST_ACCESS;
        ST_ACCESS: if (apb_ready) begin
          st      <= ST_IDLE;
          last_wr <= cur_wr;
        end
        default:   st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OK;
      rvalid_q <= 1'b0;
      rresp_q  <= RESP_OK;
      rdata_q  <= '0;
    end else begin
      if (bvalid_q && axi_bready) bvalid_q <= 1'b0;
      if (rvalid_q && axi_rready) rvalid_q <= 1'b0;
      if (done && cur_wr) begin
        bvalid_q <= 1'b1;
        bresp_q  <= apb_err ? RESP_ERR : RESP_OK;
      end
      if (done && !cur_wr) begin
        rvalid_q <= 1'b1;
        rresp_q  <= apb_err ? RESP_ERR : RESP_OK;
        rdata_q  <= apb_rdata;
      end
    end
  end

  AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    apb_sel && !apb_en |=> apb_sel && apb_en); // R2
  AST_EN_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    apb_en |-> apb_sel); // R2
  AST_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    apb_sel && apb_en && !apb_ready |=> apb_sel && apb_en && $stable(apb_addr)
      && $stable(apb_write) && $stable(apb_wdata)); // R3
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    apb_sel && apb_en && apb_ready |=> !apb_sel); // R4
  AST_WRITE_BOTH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    apb_sel && !apb_en && apb_write |-> !axi_awready && !axi_wready); // R5
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    axi_bvalid && !axi_bready |=> axi_bvalid && $stable(axi_bresp)); // R8
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    axi_rvalid && !axi_rready |=> axi_rvalid && $stable(axi_rresp) && $stable(axi_rdata)); // R8
  AST_NO_AW_WHILE_B: assert property (@(posedge clk) disable iff (!rst_n)
    axi_bvalid |-> !axi_awready && !axi_wready); // R9
  AST_NO_AR_WHILE_R: assert property (@(posedge clk) disable iff (!rst_n)
    axi_rvalid |-> !axi_arready); // R9

endmodule

// File: tb/axil_apb_bridge_tb.sv
`timescale 1ns/1ps
module axil_apb_bridge_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] awaddr = '0, wdata = '0, araddr = '0, rdata, paddr, pwdata;
  logic awvalid = 0, awready, wvalid = 0, wready, bvalid, bready = 0;
  logic arvalid = 0, arready, rvalid, rready = 0;
  logic [1:0] bresp, rresp;
  logic psel, penable, pwrite;
  logic [31:0] prdata = '0;
  logic pready = 0, pslverr = 0;

  axil_apb_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .axi_awaddr(awaddr), .axi_awvalid(awvalid), .axi_awready(awready),
    .axi_wdata(wdata), .axi_wvalid(wvalid), .axi_wready(wready),
    .axi_bresp(bresp), .axi_bvalid(bvalid), .axi_bready(bready),
    .axi_araddr(araddr), .axi_arvalid(arvalid), .axi_arready(arready),
    .axi_rdata(rdata), .axi_rresp(rresp), .axi_rvalid(rvalid), .axi_rready(rready),
    .apb_sel(psel), .apb_en(penable), .apb_addr(paddr), .apb_write(pwrite),
    .apb_wdata(pwdata), .apb_rdata(prdata), .apb_ready(pready), .apb_err(pslverr)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  logic dir_log [64];
  int log_n = 0;
  int force_wait = 0;
  bit aw_seen = 0, w_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_err(input logic [31:0] a);
    return a[7:6] == 2'b11;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    return is_err(a) ? (32'hBAD0_0000 | {16'h0, a[15:0]}) : shadow[a[5:2]];
  endfunction

  function automatic logic [1:0] exp_resp(input logic [31:0] a);
    return is_err(a) ? 2'b10 : 2'b00;
  endfunction

  // APB completer model and protocol observer
  int ph = 0, wcnt = 0;
  bit done_prev = 0;
  logic [31:0] s_addr, s_wd;
  logic s_wr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) chk(!psel, "R4 idle after completion", {31'b0, psel}, 32'd0);
      done_prev = 0;
      if (ph == 1) chk(psel && penable, "R2 access follows setup", {30'b0, psel, penable}, 32'd3);
      if (psel && !penable) begin
        chk(ph == 0, "R4 setup only from idle", ph, 0);
        ph = 1;
        s_addr = paddr; s_wr = pwrite; s_wd = pwdata;
        wcnt = (force_wait != 0) ? force_wait : int'($urandom % 4);
        if (log_n < 64) dir_log[log_n] = pwrite;
        log_n++;
        if (pwrite) chk(aw_seen && w_seen, "R5 write after AW and W", {30'b0, aw_seen, w_seen}, 32'd3);
        pready = 0;
      end else if (psel && penable) begin
        chk(ph != 0, "R2 access without setup", ph, 1);
        ph = 2;
        chk(paddr == s_addr && pwrite == s_wr && (!pwrite || pwdata == s_wd),
            "R3 stable during access", paddr, s_addr);
        if (wcnt == 0) begin
          pready = 1;
          pslverr = is_err(paddr);
          prdata = is_err(paddr) ? (32'hBAD0_0000 | {16'h0, paddr[15:0]}) : mem[paddr[5:2]];
          if (pwrite && !is_err(paddr)) mem[paddr[5:2]] = pwdata;
          done_prev = 1;
          ph = 0;
        end else begin
          pready = 0;
          wcnt--;
        end
      end else begin
        pready = 0;
        pslverr = 0;
        ph = 0;
      end
    end
  end

  task automatic axi_write(input logic [31:0] a, input logic [31:0] d,
                           input int adly, input int wdly, input int bdly);
    logic [1:0] r;
    fork
      begin
        bit ok;
        repeat (adly) begin @(posedge clk); #1; end
        awaddr = a; awvalid = 1;
        do begin @(negedge clk); ok = awready; @(posedge clk); #1; end while (!ok);
        aw_seen = 1; awvalid = 0;
      end
      begin
        bit ok;
        repeat (wdly) begin @(posedge clk); #1; end
        wdata = d; wvalid = 1;
        do begin @(negedge clk); ok = wready; @(posedge clk); #1; end while (!ok);
        w_seen = 1; wvalid = 0;
      end
    join
    do @(negedge clk); while (!bvalid);
    r = bresp;
    chk(r == exp_resp(a), "R7 write response", {30'b0, r}, {30'b0, exp_resp(a)});
    for (int i = 0; i < bdly; i++) begin
      chk(!awready && !wready, "R9 no AW/W while B pending", {30'b0, awready, wready}, 32'd0);
      @(negedge clk);
      chk(bvalid && bresp == r, "R8 B held", {29'b0, bvalid, bresp}, {29'b0, 1'b1, r});
    end
    @(posedge clk); #1 bready = 1;
    @(posedge clk); #1 bready = 0;
    aw_seen = 0; w_seen = 0;
    if (!is_err(a)) shadow[a[5:2]] = d;
  endtask

  task automatic axi_read(input logic [31:0] a, input int adly, input int rdly);
    bit ok;
    logic [31:0] d;
    logic [1:0] r;
    repeat (adly) begin @(posedge clk); #1; end
    araddr = a; arvalid = 1;
    do begin @(negedge clk); ok = arready; @(posedge clk); #1; end while (!ok);
    arvalid = 0;
    do @(negedge clk); while (!rvalid);
    d = rdata; r = rresp;
    chk(d == exp_rd(a), "R7 read data", d, exp_rd(a));
    chk(r == exp_resp(a), "R7 read response", {30'b0, r}, {30'b0, exp_resp(a)});
    for (int i = 0; i < rdly; i++) begin
      chk(!arready, "R9 no AR while R pending", {31'b0, arready}, 32'd0);
      @(negedge clk);
      chk(rvalid && rdata == d && rresp == r, "R8 R held", rdata, d);
    end
    @(posedge clk); #1 rready = 1;
    @(posedge clk); #1 rready = 0;
  endtask

  function automatic logic [31:0] mk_addr(input int idx, input bit err);
    return {24'h0, err ? 2'b11 : 2'b00, idx[3:0], 2'b00};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h1000_0000 + i;
      shadow[i] = 32'h1000_0000 + i;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!psel && !penable, "R1 APB idle in reset", {30'b0, psel, penable}, 32'd0);
    chk(!bvalid && !rvalid, "R1 no response in reset", {30'b0, bvalid, rvalid}, 32'd0);
    chk(awready && wready && arready, "R1 ready in reset", {29'b0, awready, wready, arready}, 32'd7);
    rst_n = 1;
    @(posedge clk); #1;

    // R6 simultaneous requests after reset: write first
    fork
      axi_write(mk_addr(0, 0), 32'hA5A5_0001, 0, 0, 0);
      axi_read(mk_addr(8, 0), 0, 0);
    join
    chk(log_n == 2 && dir_log[0] == 1 && dir_log[1] == 0, "R6 write first after reset",
        {31'b0, dir_log[0]}, 32'd1);
    axi_write(mk_addr(1, 0), 32'hA5A5_0002, 0, 0, 0);
    fork
      axi_write(mk_addr(2, 0), 32'hA5A5_0003, 0, 0, 0);
      axi_read(mk_addr(9, 0), 0, 0);
    join
    chk(log_n == 5 && dir_log[3] == 0 && dir_log[4] == 1, "R6 read first after a write",
        {31'b0, dir_log[3]}, 32'd0);

    // R5 AW and W in either order
    axi_write(mk_addr(3, 0), 32'h0000_3333, 0, 6, 2);
    axi_write(mk_addr(4, 0), 32'h0000_4444, 6, 0, 2);
    // R3 long wait states, R7 error paths
    force_wait = 40;
    axi_write(mk_addr(5, 0), 32'h0000_5555, 0, 0, 0);
    axi_read(mk_addr(5, 0), 0, 0);
    force_wait = 0;
    axi_write(mk_addr(6, 1), 32'hDEAD_BEEF, 0, 0, 3);
    axi_read(mk_addr(6, 1), 0, 3);
    axi_read(mk_addr(6, 0), 0, 0);

    // Random concurrent phase: writer on 0..7, reader on 8..15
    fork
      for (int k = 0; k < 60; k++)
        axi_write(mk_addr($urandom % 8, ($urandom % 5) == 0), $urandom,
                  $urandom % 4, $urandom % 4, $urandom % 4);
      for (int k = 0; k < 60; k++)
        axi_read(mk_addr(8 + $urandom % 8, ($urandom % 5) == 0), $urandom % 4, $urandom % 4);
    join
    for (int i = 0; i < 8; i++) axi_read(mk_addr(i, 0), 0, 0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule